// File: doc/BRIEF.md
# Superframe Descrambling Sequence Generator

This block removes the scrambling from the received bits of one TDMA superframe. A 44-bit linear feedback shift register is seeded from three identity fields of the system: a 20-bit network identifier, a 12-bit system identifier and a 12-bit color code. Each register step yields one sequence bit. That bit is XORed with one received bit.

The timeslot at which reception starts is given as an offset. After a load strobe the block advances the register once per cycle, with no output, to the sequence position that matches the first received bit. During this skip phase it raises a busy flag. It then descrambles one received bit for every cycle in which the input valid is high, and the result appears one cycle later with its own valid. The sequence is 4320 bits long. At that length it starts again from the seed. A pass ends after 4300 output bits, and a new load strobe restarts the block at any time.

Top module: `sf_descrambler`

## Requirements
- R1: The register seed is the 44-bit value {network id, system id, color code}: the network id sits in bits 43..24, the system id in bits 23..12 and the color code in bits 11..0. An all-zero seed therefore passes data through unchanged.
- R2: Each sequence bit is register bit 43. On a step the register shifts left by one, and bit 0 takes the XOR of bits 43, 33, 19, 14, 8 and 3.
- R3: After a load strobe, busy is high for exactly 20 + 360·offset cycles. Offset values above 11 count as 11. No output valid appears while busy is high, and input valid is ignored during that time.
- R4: The k-th accepted received bit (k from 0) leaves as its XOR with sequence bit (k + 20 + 360·offset) mod 4320. The output valid comes one cycle after the input is accepted.
- R5: Sequence position 4320 is position 0 again: the register reloads from the seed after position 4319.
- R6: A pass delivers exactly 4300 output bits. Input valid after the 4300th bit produces no output until the next load.
- R7: A load strobe during a skip or a pass drops the old pass and restarts with the new seed and offset.
- R8: The sequence advances only on cycles with an accepted input bit, so gaps in input valid do not shift the alignment.
- R9: After reset busy and output valid are low, and input valid produces no output until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe: capture seed fields and offset, restart |
| net_id_i | input | 20 | Network identifier seed field |
| sys_id_i | input | 12 | System identifier seed field |
| color_i | input | 12 | Color code seed field |
| slot_off_i | input | 4 | Timeslot offset of the first received bit (0..11) |
| rx_bit_i | input | 1 | Received scrambled bit |
| rx_valid_i | input | 1 | Received bit valid |
| busy_o | output | 1 | High while the skip phase runs |
| dsc_bit_o | output | 1 | Descrambled bit |
| dsc_valid_o | output | 1 | Descrambled bit valid |

## Verification
The properties assume that load_i is a single-cycle strobe. They also assume that a received bit counts only when the block is in its run phase, so an output valid always traces back to an input valid one cycle earlier that did not coincide with a load. The stimulus pulses load for exactly one cycle. It holds input valid high during every skip phase, to show that such bits are dropped. It keeps feeding bits past the 4300th, to show the end of the pass. Offsets of 0, 5 and 11 cover the cases with and without a wrap at 4320, and an offset of 15 checks the clamp.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int NET_W     = 20;
  localparam int SYS_W     = 12;
  localparam int CC_W      = 12;
  localparam int SEED_W    = NET_W + SYS_W + CC_W;
  localparam int SEQ_LEN   = 4320;
  localparam int PASS_BITS = 4300;
  localparam int SYNC_SKIP = 20;
  localparam int SLOT_BITS = 360;
  localparam int SLOTS     = 12;
  localparam int OFF_W     = $clog2(SLOTS);
  localparam int IDX_W     = $clog2(SEQ_LEN);
  localparam int CNT_W     = $clog2(PASS_BITS + 1);

  localparam logic [SEED_W-1:0] TAP_MASK =
    (SEED_W'(1) << 43) | (SEED_W'(1) << 33) | (SEED_W'(1) << 19) |
    (SEED_W'(1) << 14) | (SEED_W'(1) << 8)  | (SEED_W'(1) << 3);

  typedef enum logic [1:0] {ST_IDLE, ST_SKIP, ST_RUN} sfd_state_e;

  function automatic logic [IDX_W-1:0] skip_len(input logic [OFF_W-1:0] off);
    logic [OFF_W-1:0] oc;
    oc = (off > OFF_W'(SLOTS - 1)) ? OFF_W'(SLOTS - 1) : off;
    return IDX_W'(SYNC_SKIP) + IDX_W'(SLOT_BITS) * IDX_W'(oc);
  endfunction
endpackage

// File: rtl/sfd_lfsr.sv
module sfd_lfsr
  import sfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              step_i,
  input  logic              wrap_i,
  output logic              seq_bit_o
);
  logic [SEED_W-1:0] seed_q, seed_d;
  logic [SEED_W-1:0] sr_q, sr_d;
  logic              fb;

  always_comb begin
    fb     = ^(sr_q & TAP_MASK);
    seed_d = load_i ? seed_i : seed_q;
    if (load_i)      sr_d = seed_i;
    else if (wrap_i) sr_d = seed_q;
    else if (step_i) sr_d = {sr_q[SEED_W-2:0], fb};
    else             sr_d = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= '0;
      sr_q   <= '0;
    end else begin
      seed_q <= seed_d;
      sr_q   <= sr_d;
    end
  end

  assign seq_bit_o = sr_q[SEED_W-1];
endmodule

// File: rtl/sfd_ctrl.sv
module sfd_ctrl
  import sfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic             rx_valid_i,
  output logic             step_o,
  output logic             wrap_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] seq_idx_o
);
  sfd_state_e       state_q, state_d;
  logic [IDX_W-1:0] skip_q, skip_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] out_q, out_d;
  logic [IDX_W-1:0] skip_init;

  always_comb begin
    skip_init = skip_len(offset_i);
    accept_o  = !load_i && (state_q == ST_RUN) && rx_valid_i;
    step_o    = (!load_i && (state_q == ST_SKIP)) || accept_o;
    wrap_o    = step_o && (idx_q == IDX_W'(SEQ_LEN - 1));

    state_d = state_q;
    skip_d  = skip_q;
    out_d   = out_q;
    if (wrap_o)      idx_d = '0;
    else if (step_o) idx_d = idx_q + 1'b1;
    else             idx_d = idx_q;

    if (load_i) begin
      idx_d   = '0;
      out_d   = '0;
      skip_d  = skip_init;
      state_d = (skip_init == '0) ? ST_RUN : ST_SKIP;
    end else begin
      case (state_q)
        ST_SKIP: begin
          skip_d = skip_q - 1'b1;
          if (skip_q == IDX_W'(1)) state_d = ST_RUN;
        end
        ST_RUN: begin
          if (accept_o) begin
            out_d = out_q + 1'b1;
            if (out_q == CNT_W'(PASS_BITS - 1)) state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      skip_q  <= '0;
      idx_q   <= '0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      skip_q  <= skip_d;
      idx_q   <= idx_d;
      out_q   <= out_d;
    end
  end

  assign busy_o    = (state_q == ST_SKIP);
  assign seq_idx_o = idx_q;
endmodule

// File: rtl/sf_descrambler.sv
module sf_descrambler
  import sfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NET_W-1:0] net_id_i,
  input  logic [SYS_W-1:0] sys_id_i,
  input  logic [CC_W-1:0]  color_i,
  input  logic [OFF_W-1:0] slot_off_i,
  input  logic             rx_bit_i,
  input  logic             rx_valid_i,
  output logic             busy_o,
  output logic             dsc_bit_o,
  output logic             dsc_valid_o
);
  logic              rst_meta, rst_sn;
  logic              step, wrap, accept, seq_bit;
  logic [IDX_W-1:0]  seq_idx;
  logic [SEED_W-1:0] seed;
  logic              dbit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  assign seed = {net_id_i, sys_id_i, color_i};

  sfd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sn), .load_i(load_i), .offset_i(slot_off_i),
    .rx_valid_i(rx_valid_i), .step_o(step), .wrap_o(wrap),
    .accept_o(accept), .busy_o(busy_o), .seq_idx_o(seq_idx)
  );

  sfd_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_sn), .load_i(load_i), .seed_i(seed),
    .step_i(step), .wrap_i(wrap), .seq_bit_o(seq_bit)
  );

  always_comb dbit_d = accept ? (rx_bit_i ^ seq_bit) : dsc_bit_o;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dsc_bit_o   <= 1'b0;
      dsc_valid_o <= 1'b0;
    end else begin
      dsc_bit_o   <= dbit_d;
      dsc_valid_o <= accept;
    end
  end
endmodule

// File: rtl/sfd_chk.sv
module sfd_chk
  import sfd_pkg::*;
(
  input logic             clk,
  input logic             rst_sn,
  input logic             load_i,
  input logic             rx_valid_i,
  input logic             busy_o,
  input logic             dsc_valid_o,
  input logic             step,
  input logic [IDX_W-1:0] seq_idx
);
  // R3: nothing leaves while the skip phase runs
  a_r3_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    busy_o |-> !dsc_valid_o);

  // R4: every output traces to an input valid one cycle before, not on a load
  a_r4_valid_from_input: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(dsc_valid_o) |-> ($past(rx_valid_i) && !$past(load_i)));

  // R7: a load always restarts with a skip phase and no output
  a_r7_load_restarts: assert property (@(posedge clk) disable iff (!rst_sn)
    load_i |=> (busy_o && !dsc_valid_o));

  // R5: the sequence position returns to 0 after the last position
  a_r5_index_wraps: assert property (@(posedge clk) disable iff (!rst_sn)
    (step && !load_i && seq_idx == IDX_W'(SEQ_LEN - 1)) |=> (seq_idx == '0));

  // R5: the position never leaves the sequence
  a_r5_index_bound: assert property (@(posedge clk) disable iff (!rst_sn)
    seq_idx < IDX_W'(SEQ_LEN));
endmodule

bind sf_descrambler sfd_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .load_i(load_i), .rx_valid_i(rx_valid_i),
  .busy_o(busy_o), .dsc_valid_o(dsc_valid_o), .step(step), .seq_idx(seq_idx)
);

// File: tb/sf_descrambler_bench.sv
module sf_descrambler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [19:0] net_id_i = '0;
  logic [11:0] sys_id_i = '0;
  logic [11:0] color_i = '0;
  logic [3:0]  slot_off_i = '0;
  logic        rx_bit_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic        busy_o, dsc_bit_o, dsc_valid_o;

  int checks = 0;
  int failures = 0;
  bit ref_seq [4320];
  bit in_bits [4400];
  bit out_bits [32768];
  int out_cnt = 0;
  int base = 0;
  int n_in = 0;

  always #10 clk = ~clk;

  sf_descrambler u_sf_descrambler (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .net_id_i(net_id_i),
    .sys_id_i(sys_id_i), .color_i(color_i), .slot_off_i(slot_off_i),
    .rx_bit_i(rx_bit_i), .rx_valid_i(rx_valid_i), .busy_o(busy_o),
    .dsc_bit_o(dsc_bit_o), .dsc_valid_o(dsc_valid_o)
  );

  always @(negedge clk) begin
    if (dsc_valid_o) begin
      out_bits[out_cnt % 32768] = dsc_bit_o;
      out_cnt = out_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gen_ref(input logic [43:0] s);
    logic [43:0] r;
    r = s;
    for (int p = 0; p < 4320; p++) begin
      ref_seq[p] = r[43];
      r = {r[42:0], r[43] ^ r[33] ^ r[19] ^ r[14] ^ r[8] ^ r[3]};
    end
  endtask

  // load, hold input valid through the skip, measure busy (R3)
  task automatic start_pass(input logic [19:0] n, input logic [11:0] s,
                            input logic [11:0] c, input int off);
    int busy_n, exp_n;
    exp_n = 20 + 360 * ((off > 11) ? 11 : off);
    gen_ref({n, s, c});
    @(negedge clk); #1;
    base = out_cnt;
    n_in = 0;
    net_id_i = n; sys_id_i = s; color_i = c; slot_off_i = 4'(off);
    load_i = 1'b1; rx_valid_i = 1'b0;
    @(negedge clk);
    load_i = 1'b0; rx_valid_i = 1'b1; rx_bit_i = 1'b1;
    busy_n = 0;
    while (busy_o && busy_n < 5000) begin
      busy_n++;
      @(negedge clk);
    end
    rx_valid_i = 1'b0;
    #1;
    check("R3 busy length", busy_n, exp_n);
    check("R3 no output during skip", out_cnt - base, 0);
  endtask

  task automatic feed(input int nbits, input bit gaps);
    int cyc = 0;
    int cnt = 0;
    while (cnt < nbits) begin
      @(negedge clk);
      rx_valid_i = !gaps || (cyc % 3 != 1);
      rx_bit_i = 1'($urandom);
      if (rx_valid_i) begin
        in_bits[n_in] = rx_bit_i;
        n_in++;
        cnt++;
      end
      cyc++;
    end
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic compare(input string req, input int off, input int nexp);
    int bad = 0;
    int first = -1;
    int got;
    repeat (2) @(negedge clk);
    #1;
    got = out_cnt - base;
    for (int k = 0; k < nexp && k < got; k++) begin
      if (out_bits[(base + k) % 32768] !=
          (in_bits[k] ^ ref_seq[(k + 20 + 360 * off) % 4320])) begin
        if (first < 0) first = k;
        bad++;
      end
    end
    check({req, " mismatched bits"}, bad, 0);
    if (first >= 0)
      $display("  first mismatch at bit %0d", first);
  endtask

  task automatic t_reset;
    check("R9 busy after reset", int'(busy_o), 0);
    check("R9 valid after reset", int'(dsc_valid_o), 0);
    base = out_cnt;
    repeat (20) begin
      @(negedge clk);
      rx_valid_i = 1'b1; rx_bit_i = 1'($urandom);
    end
    @(negedge clk); rx_valid_i = 1'b0;
    @(negedge clk); #1;
    check("R9 no output before load", out_cnt - base, 0);
  endtask

  task automatic t_full(input string req, input logic [19:0] n, input logic [11:0] s,
                        input logic [11:0] c, input int off, input bit gaps);
    start_pass(n, s, c, off);
    feed(4300 + 8, gaps);
    compare(req, off, 4300);
    check("R6 output count per pass", out_cnt - base, 4300);
    check("R6 idle after pass", int'(busy_o), 0);
  endtask

  task automatic t_abort;
    start_pass(20'h5A5A5, 12'h3C3, 12'hA5A, 3);
    feed(50, 1'b0);
    t_full("R7 restart after load", 20'h0F0F1, 12'h123, 12'h456, 2, 1'b0);
  endtask

  task automatic t_clamp;
    start_pass(20'h11111, 12'h222, 12'h333, 15);
    feed(30, 1'b0);
    compare("R3 clamped offset", 11, 30);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    t_full("R4 R2 offset 0", 20'hBEE01, 12'h5C1, 12'h2F3, 0, 1'b0);
    t_full("R1 zero seed passthrough", 20'h0, 12'h0, 12'h0, 0, 1'b0);
    t_full("R8 gapped valid offset 5", 20'h8A3C1, 12'hF0E, 12'h0D7, 5, 1'b1);
    t_full("R5 wrap offset 11", 20'h7FFFE, 12'h001, 12'hC35, 11, 1'b0);
    t_abort();
    t_clamp();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule